// File: doc/BRIEF.md
# I2C Address Phase Sequencer

This block runs the address phase of an I2C transaction on behalf of a transfer requester. It takes one request at a time: a target address and a direction flag. It decides from the address value alone whether the target uses 7-bit or 10-bit addressing, and it rejects illegal addresses before the bus is touched. For a legal address it commands a downstream byte engine to generate a START condition and then one or two address bytes. It never commands a STOP.

The byte engine takes one command at a time. It answers each command with a single-cycle completion pulse, an acknowledge flag and a bus-error flag. The sequencer waits for that pulse before it moves to the next step. When the sequence ends, the requester gets a one-cycle result pulse and a 2-bit status code: success, invalid address, not acknowledged, or bus error. Data bytes and the closing STOP belong to later stages.

Top module: `i2c_addr_seq`

## Requirements
- R1: After a synchronous active-low reset the block is idle: `req_ready` is 1, and `cmd_valid` and `rsp_done` are 0.
- R2: An address of 0x400 or more completes with status INVALID (code 1) and issues no engine command.
- R3: An address below 0x80 whose bits 6..3 are all ones (address AND 0x78 equals 0x78) completes with status INVALID (code 1) and issues no engine command.
- R4: For every legal address, the first engine command is START (op code 0).
- R5: For an address below 0x80, exactly one write command (op code 1) follows START. Its byte is {address[6:0], rw}, where rw=1 means read. An acknowledge on it ends the request with status OK (code 0).
- R6: For an address from 0x80 to 0x3FF, two write commands follow START. The first byte is 8'hF0 OR address[9:7] (bits 2..0). The second byte is {address[6:0], rw}. Acknowledges on both end the request with status OK.
- R7: If the first byte of a 10-bit sequence is not acknowledged, the request ends with status NACK (code 2) and the second byte is never commanded.
- R8: The sequencer never issues a STOP command (op code 2). Every address byte is a plain write.
- R9: An engine completion with the bus-error flag set, at any step, ends the request with status BUS_ERROR (code 3), and no further command is issued.
- R10: A missing acknowledge on the only byte of a 7-bit sequence, or on the second byte of a 10-bit sequence, ends the request with status NACK.
- R11: `req_ready` is 1 only while idle. Request inputs presented while busy are ignored. Each accepted request produces exactly one single-cycle `rsp_done` pulse.
- R12: At most one engine command is outstanding. `cmd_valid` is a one-cycle pulse, and the next command comes only after the engine's completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and accepting a request |
| req_addr | input | 11 | Target address; values from 0x400 up are illegal |
| req_rw | input | 1 | Direction bit placed in the address byte, 1 = read |
| cmd_valid | output | 1 | One-cycle engine command strobe |
| cmd_op | output | 2 | Engine operation: 0 START, 1 WRITE, 2 STOP, 3 READ |
| cmd_byte | output | 8 | Byte to write for a WRITE command |
| eng_done | input | 1 | Engine completion pulse for the outstanding command |
| eng_ack | input | 1 | Byte was acknowledged, valid with eng_done |
| eng_err | input | 1 | Bus error on the command, valid with eng_done |
| rsp_done | output | 1 | One-cycle end-of-request pulse |
| rsp_status | output | 2 | 0 OK, 1 INVALID, 2 NACK, 3 BUS_ERROR; valid with rsp_done |

## Verification
A wrong state in the sequencer shows at the ports in one of three ways. It can issue an extra or a missing engine command. It can put a byte with the wrong prefix or direction bit on `cmd_byte`. It can report a status code that does not match the step that failed. Each of these appears within one engine round trip of the faulty step, which is a few cycles. A stuck state shows as a `rsp_done` that never arrives, and the per-request timeout catches it. Each request is checked for its status, the number of commands, and the opcode and byte of every command. Error and missing-acknowledge responses are placed on each step of both address modes, so every exit from the state machine is compared.

// File: rtl/i2c_addr_seq_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the address phase sequencer.
// Assumes: status and opcode values are also decoded by the requester and the byte engine.
package i2c_addr_seq_pkg;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_INVALID = 2'd1,
        ST_NACK    = 2'd2,
        ST_BUS_ERR = 2'd3
    } seq_status_t;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_STOP  = 2'd2,
        OP_READ  = 2'd3
    } eng_op_t;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_CHECK   = 3'd1,
        S_START   = 3'd2,
        S_SEND_HI = 3'd3,
        S_SEND_LO = 3'd4,
        S_DONE    = 3'd5
    } seq_state_t;

endpackage

// File: rtl/i2c_addr_classify.sv
`timescale 1ns/1ps
// Address classifier: decides legality and mode and builds the address bytes.
// Assumes: purely combinational; the address is held stable by the caller.
module i2c_addr_classify #(
    parameter int REQ_W      = 11,
    parameter int BYTE_W     = 8,
    parameter int LONG_BITS  = 10,
    parameter int SHORT_BITS = 7
) (
    input  logic [REQ_W-1:0]  addr,
    input  logic              rw,
    output logic              invalid,
    output logic              ten_bit,
    output logic [BYTE_W-1:0] hi_byte,
    output logic [BYTE_W-1:0] lo_byte
);

    localparam int               WORD_W     = 2 * BYTE_W;
    localparam logic [REQ_W-1:0] SHORT_LIM  = REQ_W'(1) << SHORT_BITS;
    localparam logic [REQ_W-1:0] LONG_LIM   = REQ_W'(1) << LONG_BITS;
    localparam logic [REQ_W-1:0] CLASH_MASK = REQ_W'(8'h78);
    localparam logic [WORD_W-1:0] PREFIX    = WORD_W'(16'hF000);

    logic              is_short;
    logic              too_big;
    logic              clash;
    logic [WORD_W-1:0] word;

    // Classify the address range and the prefix-pattern collision.
    always_comb begin
        is_short = addr < SHORT_LIM;
        too_big  = addr >= LONG_LIM;
        clash    = is_short && ((addr & CLASH_MASK) == CLASH_MASK);
        invalid  = too_big || clash;
        ten_bit  = !is_short && !too_big;
    end

    // Build the 16-bit address word; the low byte doubles as the 7-bit byte.
    always_comb begin
        word    = PREFIX | (WORD_W'(addr) << 1) | WORD_W'(rw);
        hi_byte = word[WORD_W-1:BYTE_W];
        lo_byte = word[BYTE_W-1:0];
    end

endmodule

// File: rtl/i2c_addr_seq_fsm.sv
`timescale 1ns/1ps
// Sequencer state machine: accepts a request, commands START and the address bytes, reports status.
// Assumes: the engine raises eng_done for one cycle, at least one cycle after cmd_valid.
module i2c_addr_seq_fsm
    import i2c_addr_seq_pkg::*;
#(
    parameter int REQ_W  = 11,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [REQ_W-1:0]  req_addr,
    input  logic              req_rw,
    output logic [REQ_W-1:0]  addr_q,
    output logic              rw_q,
    input  logic              cls_invalid,
    input  logic              cls_ten,
    input  logic [BYTE_W-1:0] cls_hi,
    input  logic [BYTE_W-1:0] cls_lo,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [BYTE_W-1:0] cmd_byte,
    input  logic              eng_done,
    input  logic              eng_ack,
    input  logic              eng_err,
    output logic              rsp_done,
    output logic [1:0]        rsp_status
);

    seq_state_t  state, state_d;
    seq_status_t status_q, status_d;
    logic        issued;
    logic        step_done;

    assign step_done = issued && eng_done;

    // Choose the next state and the result code.
    always_comb begin
        state_d  = state;
        status_d = status_q;
        case (state)
            S_IDLE: begin
                if (req_valid) begin
                    state_d  = S_CHECK;
                    status_d = ST_OK;
                end
            end
            S_CHECK: begin
                if (cls_invalid) begin
                    state_d  = S_DONE;
                    status_d = ST_INVALID;
                end else begin
                    state_d = S_START;
                end
            end
            S_START: begin
                if (step_done) begin
                    if (eng_err) begin
                        state_d  = S_DONE;
                        status_d = ST_BUS_ERR;
                    end else begin
                        state_d = S_SEND_HI;
                    end
                end
            end
            S_SEND_HI: begin
                if (step_done) begin
                    state_d = S_DONE;
                    if (eng_err)       status_d = ST_BUS_ERR;
                    else if (!eng_ack) status_d = ST_NACK;
                    else if (cls_ten)  state_d  = S_SEND_LO;
                    else               status_d = ST_OK;
                end
            end
            S_SEND_LO: begin
                if (step_done) begin
                    state_d = S_DONE;
                    if (eng_err)       status_d = ST_BUS_ERR;
                    else if (!eng_ack) status_d = ST_NACK;
                    else               status_d = ST_OK;
                end
            end
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Hold state, result and the captured request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            status_q <= ST_OK;
            addr_q   <= '0;
            rw_q     <= 1'b0;
        end else begin
            state    <= state_d;
            status_q <= status_d;
            if (state == S_IDLE && req_valid) begin
                addr_q <= req_addr;
                rw_q   <= req_rw;
            end
        end
    end

    // Remember that the current step's command has gone out.
    always_ff @(posedge clk) begin
        if (!rst_n)                issued <= 1'b0;
        else if (state_d != state) issued <= 1'b0;
        else if (cmd_valid)        issued <= 1'b1;
    end

    // Drive the engine command and the requester handshake.
    always_comb begin
        req_ready  = (state == S_IDLE);
        cmd_valid  = (state == S_START || state == S_SEND_HI || state == S_SEND_LO) && !issued;
        cmd_op     = (state == S_START) ? OP_START : OP_WRITE;
        cmd_byte   = (state == S_SEND_HI && cls_ten) ? cls_hi : cls_lo;
        rsp_done   = (state == S_DONE);
        rsp_status = status_q;
    end

    // R11: the result is a single-cycle pulse
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R11: never ready while reporting
    p_busy_not_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !req_ready);

    // R12: a command strobe never lasts two cycles
    p_single_cmd_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R8: no STOP is ever commanded
    p_no_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_op != OP_STOP);

    // R6: a 10-bit first byte carries the prefix pattern
    p_prefix_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && state == S_SEND_HI && cls_ten) |-> cmd_byte[BYTE_W-1:BYTE_W-5] == 5'b11110);

    // R7: an unacknowledged first byte ends the sequence as NACK
    p_nack_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SEND_HI && step_done && !eng_err && !eng_ack) |=> (rsp_done && rsp_status == ST_NACK));

    // R2: an illegal address goes straight to the result
    p_invalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CHECK && cls_invalid) |=> (rsp_done && rsp_status == ST_INVALID));

endmodule

// File: rtl/i2c_addr_seq.sv
`timescale 1ns/1ps
// Top of the address phase sequencer: joins the classifier and the state machine.
// Assumes: one byte engine, one request in flight.
module i2c_addr_seq #(
    parameter int REQ_W  = 11,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [REQ_W-1:0]  req_addr,
    input  logic              req_rw,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [BYTE_W-1:0] cmd_byte,
    input  logic              eng_done,
    input  logic              eng_ack,
    input  logic              eng_err,
    output logic              rsp_done,
    output logic [1:0]        rsp_status
);

    logic [REQ_W-1:0]  addr_q;
    logic              rw_q;
    logic              cls_invalid;
    logic              cls_ten;
    logic [BYTE_W-1:0] cls_hi;
    logic [BYTE_W-1:0] cls_lo;

    i2c_addr_classify #(
        .REQ_W  (REQ_W),
        .BYTE_W (BYTE_W)
    ) u_classify (
        .addr    (addr_q),
        .rw      (rw_q),
        .invalid (cls_invalid),
        .ten_bit (cls_ten),
        .hi_byte (cls_hi),
        .lo_byte (cls_lo)
    );

    i2c_addr_seq_fsm #(
        .REQ_W  (REQ_W),
        .BYTE_W (BYTE_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_addr    (req_addr),
        .req_rw      (req_rw),
        .addr_q      (addr_q),
        .rw_q        (rw_q),
        .cls_invalid (cls_invalid),
        .cls_ten     (cls_ten),
        .cls_hi      (cls_hi),
        .cls_lo      (cls_lo),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_byte    (cmd_byte),
        .eng_done    (eng_done),
        .eng_ack     (eng_ack),
        .eng_err     (eng_err),
        .rsp_done    (rsp_done),
        .rsp_status  (rsp_status)
    );

endmodule

// File: tb/tb_i2c_addr_seq.sv
`timescale 1ns/1ps
module tb_i2c_addr_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [10:0] req_addr;
    logic        req_rw;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [7:0]  cmd_byte;
    logic        eng_done;
    logic        eng_ack;
    logic        eng_err;
    logic        rsp_done;
    logic [1:0]  rsp_status;

    int n_cmp = 0;
    int n_bad = 0;

    int          plan_nack;
    int          plan_err;
    int          log_n;
    logic [1:0]  log_op   [0:7];
    logic [7:0]  log_byte [0:7];

    int          exp_st;
    int          exp_n;
    logic [7:0]  exp_byte [0:2];
    string       exp_tag;

    always #2.5 clk = ~clk;

    i2c_addr_seq dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_rw     (req_rw),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_byte   (cmd_byte),
        .eng_done   (eng_done),
        .eng_ack    (eng_ack),
        .eng_err    (eng_err),
        .rsp_done   (rsp_done),
        .rsp_status (rsp_status)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Byte engine model: logs each command, answers one to three cycles later.
    initial begin
        int idx;
        eng_done = 1'b0;
        eng_ack  = 1'b0;
        eng_err  = 1'b0;
        forever begin
            @(negedge clk);
            eng_done = 1'b0;
            if (rst_n === 1'b1 && cmd_valid === 1'b1) begin
                idx = log_n;
                if (log_n < 8) begin
                    log_op[log_n]   = cmd_op;
                    log_byte[log_n] = cmd_byte;
                end
                log_n++;
                repeat ($urandom_range(1, 3)) @(negedge clk);
                eng_done = 1'b1;
                eng_err  = (idx == plan_err);
                eng_ack  = (idx != plan_nack);
            end
        end
    end

    // Expected outcome from the requirements.
    task automatic compute_expect(input logic [10:0] a, input logic rw, input int nk, input int er);
        bit ten;
        bit bad;
        ten = (a >= 11'h080) && (a < 11'h400);
        bad = (a >= 11'h400) || ((a < 11'h080) && ((a & 11'h078) == 11'h078));
        exp_byte[0] = 8'h00;
        exp_byte[1] = ten ? (8'hF0 | {5'b0, a[9:7]}) : {a[6:0], rw};
        exp_byte[2] = {a[6:0], rw};
        if (bad) begin
            exp_st = 1; exp_n = 0; exp_tag = (a >= 11'h400) ? "R2" : "R3";
        end else if (er == 0) begin
            exp_st = 3; exp_n = 1; exp_tag = "R9";
        end else if (er == 1) begin
            exp_st = 3; exp_n = 2; exp_tag = "R9";
        end else if (nk == 1) begin
            exp_st = 2; exp_n = 2; exp_tag = ten ? "R7" : "R10";
        end else if (!ten) begin
            exp_st = 0; exp_n = 2; exp_tag = "R5";
        end else if (er == 2) begin
            exp_st = 3; exp_n = 3; exp_tag = "R9";
        end else if (nk == 2) begin
            exp_st = 2; exp_n = 3; exp_tag = "R10";
        end else begin
            exp_st = 0; exp_n = 3; exp_tag = "R6";
        end
    endtask

    // One request: accept, junk on the inputs while busy, wait for result, compare.
    task automatic run_req(input logic [10:0] a, input logic rw, input int nk, input int er);
        int   waited;
        int   got;
        bit   seen;
        compute_expect(a, rw, nk, er);
        plan_nack = nk;
        plan_err  = er;
        log_n     = 0;
        seen      = 1'b0;
        got       = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_rw    = rw;
        @(negedge clk);
        chk(req_ready == 1'b0, "R11 ready while busy", int'(req_ready), 0);
        req_addr  = 11'(~a);
        req_rw    = ~rw;
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = 11'($urandom);
        waited    = 0;
        while (!seen && waited < 200) begin
            if (rsp_done) begin
                seen = 1'b1;
                got  = int'(rsp_status);
            end else begin
                @(negedge clk);
                waited++;
            end
        end
        chk(seen, "R11 result pulse", int'(seen), 1);
        @(negedge clk);
        chk(rsp_done == 1'b0, "R11 single pulse", int'(rsp_done), 0);
        chk(got == exp_st, {exp_tag, " status"}, got, exp_st);
        chk(log_n == exp_n, {exp_tag, " command count"}, log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++) begin
            if (i == 0) begin
                chk(log_op[i] == 2'd0, "R4 start first", int'(log_op[i]), 0);
            end else begin
                chk(log_op[i] == 2'd1, "R8 plain write", int'(log_op[i]), 1);
                chk(log_byte[i] == exp_byte[i], (exp_n == 2 && exp_st != 3 && a < 11'h080) ? "R5 byte" : "R6 byte",
                    int'(log_byte[i]), int'(exp_byte[i]));
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 5);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1C2A));
        plan_nack = -1;
        plan_err  = -1;
        log_n     = 0;
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_addr  = '0;
        req_rw    = 1'b0;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        chk(cmd_valid == 1'b0, "R1 cmd_valid", int'(cmd_valid), 0);
        chk(rsp_done == 1'b0, "R1 rsp_done", int'(rsp_done), 0);
        rst_n = 1'b1;

        // Directed corners
        run_req(11'h000, 1'b0, -1, -1); // R5 lowest
        run_req(11'h03F, 1'b1, -1, -1); // R5 read bit
        run_req(11'h077, 1'b1, -1, -1); // R5 just below clash
        run_req(11'h078, 1'b0, -1, -1); // R3 clash
        run_req(11'h07F, 1'b1, -1, -1); // R3 clash top
        run_req(11'h080, 1'b0, -1, -1); // R6 lowest 10-bit
        run_req(11'h3FF, 1'b1, -1, -1); // R6 highest 10-bit
        run_req(11'h400, 1'b0, -1, -1); // R2 first illegal
        run_req(11'h7FF, 1'b1, -1, -1); // R2 top
        run_req(11'h2A5, 1'b0, 1, -1);  // R7 prefix not acknowledged
        run_req(11'h2A5, 1'b1, 2, -1);  // R10 low byte not acknowledged
        run_req(11'h015, 1'b0, 1, -1);  // R10 7-bit not acknowledged
        run_req(11'h015, 1'b0, -1, 0);  // R9 error on START
        run_req(11'h155, 1'b1, -1, 1);  // R9 error on first byte
        run_req(11'h155, 1'b0, -1, 2);  // R9 error on second byte

        // Random mix
        for (int k = 0; k < 80; k++) begin
            run_req(11'($urandom_range(0, 11'h7FF)), 1'($urandom),
                    int'($urandom_range(0, 4)), int'($urandom_range(0, 8)));
        end

        finish_run();
    end

endmodule